// File: doc/BRIEF.md
# Boot Processor Failover Watchdog

This block is a timer inside the system's management controller. It checks that the processor chosen as bootstrap actually starts running firmware after every hard reset. Each time the system leaves hard reset the timer is loaded with a timeout measured in pulses of a slow timebase strobe, and it counts down. Firmware that is running properly stops the timer by releasing (driving high) an active-low halt line. From then on the block does nothing more until the next hard reset.

If the countdown runs out first, the block concludes that the bootstrap processor is dead. It sets that processor's bit in a disable mask, hands the bootstrap role to the next higher-numbered processor that has not failed, and issues a one-cycle system-reset request. This repeats across successive resets until firmware halts the timer. When every processor has failed, the block stops resetting the system and raises a steady beep-code request instead. After a successful boot, or after an alarm, the next hard reset clears the mask so that the search starts again from processor 0. A reset of the controller itself, as on a power cycle, does the same.

Top module: `bsp_failover_wdt`

## Requirements
- R1: After `rst`, `cpu_disable` is all zeros, `bsp_idx` is 0, and `beep_req` and `sys_rst_pulse` are low.
- R2: The countdown starts when `hard_rst` falls. The timeout expires on the TIMEOUT_TICKS-th cycle in which `tick` is high after that release, and not before. Ticks seen while `hard_rst` is high are ignored.
- R3: Driving `fw_halt_n` high during the countdown stops the timer once the value has passed a two-flop synchroniser. After that, ticks never cause an expiry before the next `hard_rst` assertion.
- R4: On an expiry that leaves a working processor, `sys_rst_pulse` is high for exactly one cycle, and the bit of the failed processor is set in `cpu_disable`. Bit i of `cpu_disable` stands for processor i.
- R5: On that expiry `bsp_idx` moves to the next higher index whose disable bit is clear, wrapping round. The new bootstrap processor is never a disabled one.
- R6: When the expiring processor was the last one not disabled, the block sets every bit of `cpu_disable` and raises `beep_req` instead of a reset pulse. `beep_req` stays high, whatever the ticks do, until `hard_rst` is asserted.
- R7: Asserting `hard_rst` after a halt, or during the alarm, clears `cpu_disable` and sets `bsp_idx` to 0. A hard reset that follows the block's own reset request keeps the mask.
- R8: Asserting `hard_rst` in the middle of a countdown abandons it, with the mask unchanged. The full timeout starts again at the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high controller reset (power cycle) |
| hard_rst | input | 1 | High while the host system is held in hard reset |
| fw_halt_n | input | 1 | Active-low halt line from firmware; driven high to stop the timer (asynchronous) |
| tick | input | 1 | One-cycle timebase strobe that paces the countdown |
| sys_rst_pulse | output | 1 | One-cycle request to reset the host system |
| cpu_disable | output | NUM_CPU | Disable mask of processors that failed to boot |
| bsp_idx | output | IDX_W | Index of the processor selected as bootstrap |
| beep_req | output | 1 | Beep-code request, high when no working processor remains |

## Verification
The alarm is the hardest state to reach from the ports. It needs one full timeout for every processor, with a hard reset between each, and no halt anywhere along the way. The bench gets there by walking a step table: each step is one boot attempt that either lets the countdown expire or halts it after a given number of ticks. The table runs the mask up one bit at a time to all ones. It then checks that the beep persists under further ticks and that the following hard reset starts the search again from processor 0. The table also places a halted boot ahead of a fresh run, so that the mask-clearing rule after a successful boot is exercised.

// File: rtl/bfw_pkg.sv
package bfw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // host held in hard reset, waiting for release
        ST_COUNT,  // countdown running after release
        ST_PEND,   // reset requested, waiting for the host reset to assert
        ST_DONE,   // firmware halted the timer, boot accepted
        ST_ALARM   // no working processor left, beep requested
    } wdt_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bfw_sync.sv
module bfw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bfw_countdown.sv
module bfw_countdown #(
    parameter int TICKS = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = bfw_pkg::cnt_width(TICKS);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                               remain <= '0;
        else if (load)                         remain <= LOAD_VAL;
        else if (run && tick && remain != '0)  remain <= remain - 1'b1;
    end

    // Expiry is the tick that arrives with nothing left to count.
    assign expire = run && tick && (remain == '0);
endmodule

// File: rtl/bfw_selector.sv
module bfw_selector #(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_CPU-1:0] failed,
    input  logic [IDX_W-1:0]   cur,
    output logic               found,
    output logic [IDX_W-1:0]   next_idx
);
    int cand;

    // Walk offsets from far to near so the nearest live processor wins.
    always_comb begin
        found    = 1'b0;
        next_idx = '0;
        cand     = 0;
        for (int k = NUM_CPU; k >= 1; k--) begin
            cand = (int'(cur) + k) % NUM_CPU;
            if (!failed[cand]) begin
                found    = 1'b1;
                next_idx = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/bsp_failover_wdt.sv
module bsp_failover_wdt
    import bfw_pkg::*;
#(
    parameter int NUM_CPU       = 4,
    parameter int TIMEOUT_TICKS = 5000,
    parameter int SYNC_STAGES   = 2,
    localparam int IDX_W        = idx_width(NUM_CPU)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hard_rst,
    input  logic               fw_halt_n,
    input  logic               tick,
    output logic               sys_rst_pulse,
    output logic [NUM_CPU-1:0] cpu_disable,
    output logic [IDX_W-1:0]   bsp_idx,
    output logic               beep_req
);
    wdt_state_e         st_q, st_d;
    logic [NUM_CPU-1:0] fail_q, fail_d, fail_mark;
    logic [IDX_W-1:0]   bsp_q, bsp_d, pick_idx;
    logic               pulse_q, pulse_d;
    logic               halt_s, run, load, expire, pick_found;

    bfw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (fw_halt_n),
        .q_sync  (halt_s)
    );

    assign run = (st_q == ST_COUNT) && !hard_rst && !halt_s;

    bfw_countdown #(.TICKS(TIMEOUT_TICKS)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .run    (run),
        .tick   (tick),
        .expire (expire)
    );

    // Mask as it would be with the current processor marked failed.
    assign fail_mark = fail_q | (NUM_CPU'(1) << bsp_q);

    bfw_selector #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_sel (
        .failed   (fail_mark),
        .cur      (bsp_q),
        .found    (pick_found),
        .next_idx (pick_idx)
    );

    always_comb begin
        st_d    = st_q;
        fail_d  = fail_q;
        bsp_d   = bsp_q;
        pulse_d = 1'b0;
        load    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (!hard_rst) begin
                    st_d = ST_COUNT;
                    load = 1'b1;
                end
            end
            ST_COUNT: begin
                if (hard_rst) begin
                    st_d = ST_IDLE;
                end else if (halt_s) begin
                    st_d = ST_DONE;
                end else if (expire) begin
                    fail_d = fail_mark;
                    if (pick_found) begin
                        bsp_d   = pick_idx;
                        pulse_d = 1'b1;
                        st_d    = ST_PEND;
                    end else begin
                        st_d = ST_ALARM;
                    end
                end
            end
            ST_PEND: begin
                if (hard_rst) st_d = ST_IDLE;
            end
            ST_DONE, ST_ALARM: begin
                if (hard_rst) begin
                    st_d   = ST_IDLE;
                    fail_d = '0;
                    bsp_d  = '0;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            fail_q  <= '0;
            bsp_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            fail_q  <= fail_d;
            bsp_q   <= bsp_d;
            pulse_q <= pulse_d;
        end
    end

    assign sys_rst_pulse = pulse_q;
    assign cpu_disable   = fail_q;
    assign bsp_idx       = bsp_q;
    assign beep_req      = (st_q == ST_ALARM);
endmodule

// File: rtl/bfw_checker.sv
module bfw_checker #(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               hard_rst,
    input logic               sys_rst_pulse,
    input logic [NUM_CPU-1:0] cpu_disable,
    input logic [IDX_W-1:0]   bsp_idx,
    input logic               beep_req
);
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |=> !sys_rst_pulse);

    assert_pulse_marks_one_R4: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |-> ($countones(cpu_disable) == $countones($past(cpu_disable)) + 1));

    assert_bsp_live_R5: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |-> !cpu_disable[bsp_idx]);

    assert_beep_all_failed_R6: assert property (@(posedge clk) disable iff (rst)
        beep_req |-> (&cpu_disable));

    assert_beep_no_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        beep_req |-> !sys_rst_pulse);

    assert_beep_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (beep_req && !hard_rst) |=> beep_req);

    assert_mask_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !hard_rst |=> (($past(cpu_disable) & ~cpu_disable) == '0));
endmodule

bind bsp_failover_wdt bfw_checker #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_bfw_checker (
    .clk           (clk),
    .rst           (rst),
    .hard_rst      (hard_rst),
    .sys_rst_pulse (sys_rst_pulse),
    .cpu_disable   (cpu_disable),
    .bsp_idx       (bsp_idx),
    .beep_req      (beep_req)
);

// File: tb/test_bsp_failover_wdt.sv
`timescale 1ns/1ps
module test_bsp_failover_wdt;
    localparam int NCPU = 4;
    localparam int TMO  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hard_rst = 1'b1;
    logic       fw_halt_n = 1'b0;
    logic       tick = 1'b0;
    logic       sys_rst_pulse;
    logic [3:0] cpu_disable;
    logic [1:0] bsp_idx;
    logic       beep_req;

    int n_chk = 0;
    int n_bad = 0;
    int pulse_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bsp_failover_wdt #(.NUM_CPU(NCPU), .TIMEOUT_TICKS(TMO), .SYNC_STAGES(2)) i_bsp_failover_wdt (
        .clk(clk), .rst(rst), .hard_rst(hard_rst), .fw_halt_n(fw_halt_n), .tick(tick),
        .sys_rst_pulse(sys_rst_pulse), .cpu_disable(cpu_disable),
        .bsp_idx(bsp_idx), .beep_req(beep_req)
    );

    always @(posedge clk) if (sys_rst_pulse) pulse_cnt <= pulse_cnt + 1;

    // One boot attempt: halt after halt_at ticks, or let it expire.
    typedef struct packed {
        logic       do_halt;
        logic [3:0] halt_at;
        logic [3:0] exp_mask;
        logic [1:0] exp_bsp;
        logic       exp_beep;
        logic       exp_pulse;
    } step_t;

    localparam step_t STEPS [8] = '{
        '{1'b0, 4'd0, 4'b0001, 2'd1, 1'b0, 1'b1},
        '{1'b0, 4'd0, 4'b0011, 2'd2, 1'b0, 1'b1},
        '{1'b1, 4'd3, 4'b0011, 2'd2, 1'b0, 1'b0},
        '{1'b0, 4'd0, 4'b0001, 2'd1, 1'b0, 1'b1},
        '{1'b0, 4'd0, 4'b0011, 2'd2, 1'b0, 1'b1},
        '{1'b0, 4'd0, 4'b0111, 2'd3, 1'b0, 1'b1},
        '{1'b0, 4'd0, 4'b1111, 2'd3, 1'b1, 1'b0},
        '{1'b1, 4'd0, 4'b0000, 2'd0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic assert_hard();
        @(negedge clk);
        fw_halt_n = 1'b0;
        hard_rst  = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic release_hard();
        hard_rst = 1'b0;
        repeat (2) @(negedge clk);
        pulse_cnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "mask after rst", cpu_disable, 0);
        chk("R1", "bsp after rst", bsp_idx, 0);
        chk("R1", "beep after rst", beep_req, 0);
        chk("R1", "pulse after rst", sys_rst_pulse, 0);

        // Table walk: each step is one boot attempt.
        for (int s = 0; s < 8; s++) begin
            assert_hard();
            if (s == 3 || s == 7) begin
                chk("R7", "mask cleared by hard reset", cpu_disable, 0);
                chk("R7", "bsp cleared by hard reset", bsp_idx, 0);
                chk("R6", "beep cleared by hard reset", beep_req, 0);
            end
            release_hard();
            if (STEPS[s].do_halt) begin
                give_ticks(int'(STEPS[s].halt_at));
                @(negedge clk) fw_halt_n = 1'b1;
                repeat (4) @(negedge clk);
                give_ticks(TMO + 4);
                chk("R3", "no pulse after halt", pulse_cnt, 0);
            end else begin
                give_ticks(TMO - 1);
                chk("R2", "no expiry before last tick", pulse_cnt, 0);
                give_ticks(1);
            end
            repeat (2) @(negedge clk);
            chk("R4", "mask after step", cpu_disable, int'(STEPS[s].exp_mask));
            chk("R5", "bsp after step", bsp_idx, int'(STEPS[s].exp_bsp));
            chk("R6", "beep after step", beep_req, int'(STEPS[s].exp_beep));
            chk("R4", "pulses in step", pulse_cnt, int'(STEPS[s].exp_pulse));
            if (STEPS[s].exp_beep) begin
                give_ticks(20);
                chk("R6", "beep held under ticks", beep_req, 1);
                chk("R6", "no pulse in alarm", pulse_cnt, 0);
            end
        end

        // R8: hard reset mid-count restarts the whole timeout.
        assert_hard();
        release_hard();
        give_ticks(TMO - 2);
        assert_hard();
        chk("R8", "mask kept on mid-count reset", cpu_disable, 0);
        release_hard();
        give_ticks(TMO - 2);
        chk("R8", "no expiry from partial counts", pulse_cnt, 0);
        give_ticks(2);
        repeat (2) @(negedge clk);
        chk("R8", "expiry after full restart", pulse_cnt, 1);
        chk("R4", "cpu0 marked", cpu_disable, 1);

        // R2: ticks during hard reset are ignored; R7: mask kept after own reset.
        @(negedge clk) hard_rst = 1'b1;
        give_ticks(20);
        chk("R7", "mask kept after own reset", cpu_disable, 1);
        release_hard();
        give_ticks(TMO - 1);
        chk("R2", "ticks in reset ignored", pulse_cnt, 0);
        give_ticks(1);
        repeat (2) @(negedge clk);
        chk("R2", "expiry at full count", pulse_cnt, 1);
        chk("R5", "bsp advanced to 2", bsp_idx, 2);
        chk("R4", "mask 0011", cpu_disable, 3);

        // R1: controller reset clears everything.
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "mask after second rst", cpu_disable, 0);
        chk("R1", "bsp after second rst", bsp_idx, 0);

        finished = 1'b1;
        report();
    end
endmodule